// File: doc/BRIEF.md
# Parallel Flash Query Probe Engine

This block discovers a parallel NOR flash device without software help. After a `start` pulse it works out how wide the flash data bus is, checks the three-letter query signature, and then reads the device's self-description table one byte at a time. From that table it decodes the command-set code, the device size, whether the interface supports the detected width, three pairs of exponent-coded timeouts, the write-buffer size and up to `NREG` erase regions. All decoded values are held on output ports until the next `start`.

Each table byte costs four bus accesses: a query-entry command write, the read itself, and two writes that put the flash back into normal read mode. Every access is a single request/acknowledge exchange, and only one is ever open at a time. The probe ends with `done` if every check passes. Otherwise it ends with `err` and a code that names the first check that failed. A host or boot sequencer reads the result ports once either flag rises.

Top module: `fqp_engine`

## Requirements
- R1: A table byte at offset `k` is fetched as follows. Write 0x98 to address 0x55×W, where W is the bus width in bytes. Then read address k×W and take `bus_rdata[7:0]`. Every access drives `bus_be` to the low W lanes (1→0x1, 2→0x3, 4→0xF) and an address that is a multiple of W.
- R2: Every table read is followed at once by two writes to address 0. The first carries 0xF0 and the second carries 0xFF. This leaves the flash in read mode.
- R3: With `cfg_width`=0 the engine tries W=1, 2, 4 in that order and keeps the first width whose offset 0x10 reads 0x51 ('Q'). With `cfg_width` set to 1, 2 or 4 only that width is tried. If no width succeeds, the probe ends with `err_code`=1.
- R4: Offsets 0x11 and 0x12 must read 0x52 and 0x59. Otherwise the probe ends with `err_code`=2.
- R5: `cmdset` is {byte 0x14, byte 0x13}. `size_bytes` is 2 to the power of byte 0x27, or 0 when that byte is 32 or more.
- R6: The interface code {byte 0x29, byte 0x28} plus one, taken modulo 2^16 and ANDed with W, must be non-zero. Otherwise the probe ends with `err_code`=3.
- R7: The erase timeouts use a typical exponent at 0x21 and a multiplier exponent at 0x25. A zero typical exponent becomes 16 and a zero multiplier becomes 4. The probe ends with `err_code`=4 if the typical exponent is above 41 or the sum of the two is above 41.
- R8: The single-write timeouts use a typical exponent at 0x1F and a multiplier at 0x23. Zero values become 18 and 4. The limit is 51, and a failure gives `err_code`=5.
- R9: The buffered-write timeouts use a typical exponent at 0x20 and a multiplier at 0x24. They take no defaults and are checked against the limit of 51, with a failure giving `err_code`=6. `buf_log2` is byte 0x2A when the typical exponent is non-zero and 0 otherwise; in the latter case offset 0x2A is not read.
- R10: `region_count` is byte 0x2C, and a count above `NREG` gives `err_code`=7. Region g uses bytes 0x2D+4g to 0x30+4g. Its block count is the first 16-bit field plus one. Its block size is the second 16-bit field times 256, or 128 when that field is zero. Slots at or above the count read 0.
- R11: `bus_req` stays high, with a stable address, until `bus_ack`. No second access starts in the same cycle as an acknowledge.
- R12: `done` and `err` are never high together. `err_code` is 0 when `done` is high. After reset, both flags and `bus_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a probe |
| cfg_width | input | 3 | 0 for auto-detect, or a fixed width of 1, 2 or 4 |
| bus_req | output | 1 | Access request |
| bus_we | output | 1 | 1 for a write, 0 for a read |
| bus_addr | output | ADDR_W | Byte address |
| bus_wdata | output | 32 | Write data |
| bus_be | output | 4 | Byte-lane enables |
| bus_rdata | input | 32 | Read data |
| bus_ack | input | 1 | Access complete |
| done | output | 1 | Probe succeeded |
| err | output | 1 | Probe failed |
| err_code | output | 3 | Failure cause (R3 to R10) |
| width | output | 3 | Detected width in bytes |
| cmdset | output | 16 | Command-set code |
| size_bytes | output | 32 | Device size |
| erase_typ_exp | output | 8 | Erase typical exponent after defaulting |
| erase_mul_exp | output | 8 | Erase multiplier exponent after defaulting |
| write_typ_exp | output | 8 | Write typical exponent after defaulting |
| write_mul_exp | output | 8 | Write multiplier exponent after defaulting |
| buf_typ_exp | output | 8 | Buffered-write typical exponent |
| buf_mul_exp | output | 8 | Buffered-write multiplier exponent |
| buf_log2 | output | 8 | log2 of the write-buffer size |
| region_count | output | 8 | Number of erase regions |
| reg_blocks | output | NREG×17 | Block count of each region, slot 0 lowest |
| reg_bsize | output | NREG×24 | Block size of each region, slot 0 lowest |

## Verification
Each timeout rule is swept across its boundary values, including zero typical and zero multiplier exponents. A design that applied a default to the buffered pair, or that checked a limit before applying the default, would report the wrong error code or the wrong exponent. The interface code is swept against all three widths, including the all-ones code that wraps to zero when incremented. A design that tested the raw code, or that lost the wrap, would accept a device it should reject. Devices of every width are probed both by auto-detection and with a fixed width, and a fixed width that does not match the device is tried as well. A design that issued the query command at an unscaled address, or that left the device in query mode after a read, would lock onto the wrong width or be caught by the bus monitor. Region counts from zero up to one past the capacity check when the probe stops, how the zero block-size field is handled, and that unused slots are cleared.

// File: rtl/fqp_pkg.sv
// Shared constants and types for the flash query probe engine.
package fqp_pkg;
    localparam logic [7:0] CMD_QUERY  = 8'h98;
    localparam logic [7:0] CMD_RD_ALT = 8'hF0;
    localparam logic [7:0] CMD_RD_STD = 8'hFF;
    localparam logic [7:0] QUERY_ADDR = 8'h55;

    typedef enum logic [2:0] {
        ERR_NONE   = 3'd0,
        ERR_NODEV  = 3'd1,
        ERR_IDENT  = 3'd2,
        ERR_IFACE  = 3'd3,
        ERR_ERASE  = 3'd4,
        ERR_WRITE  = 3'd5,
        ERR_BUFWR  = 3'd6,
        ERR_REGION = 3'd7
    } err_e;

    typedef enum logic [1:0] {
        PH_CMD  = 2'd0,
        PH_READ = 2'd1,
        PH_RST1 = 2'd2,
        PH_RST2 = 2'd3
    } phase_e;
endpackage

// File: rtl/fqp_tmo_rule.sv
// One timeout pair rule: applies defaults to zero exponents and checks limits.
// Assumes DEF_TYP/DEF_MUL of 0 mean "no default"; purely combinational.
module fqp_tmo_rule #(
    parameter int DEF_TYP = 16,
    parameter int DEF_MUL = 4,
    parameter int LIMIT   = 41
) (
    input  logic [7:0] typ_raw,
    input  logic [7:0] mul_raw,
    output logic [7:0] typ_eff,
    output logic [7:0] mul_eff,
    output logic       bad
);
    localparam logic [7:0] DT = 8'(DEF_TYP);
    localparam logic [7:0] DM = 8'(DEF_MUL);
    localparam logic [8:0] LIM = 9'(LIMIT);

    logic [8:0] sum;

    // Defaults then limit test on the defaulted values.
    always_comb begin
        typ_eff = (typ_raw == 8'd0 && DEF_TYP != 0) ? DT : typ_raw;
        mul_eff = (mul_raw == 8'd0 && DEF_MUL != 0) ? DM : mul_raw;
        sum     = {1'b0, typ_eff} + {1'b0, mul_eff};
        bad     = ({1'b0, typ_eff} > LIM) || (sum > LIM);
    end
endmodule

// File: rtl/fqp_bus_seq.sv
// Performs one table-byte fetch as four bus accesses: query command, read,
// then two read-mode writes at address 0. Assumes width is 1, 2 or 4 and
// that the bus acknowledges each request exactly once.
module fqp_bus_seq
    import fqp_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [2:0]        width,
    input  logic [7:0]        offset,
    output logic              rsp_valid,
    output logic [7:0]        rsp_byte,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [31:0]       bus_wdata,
    output logic [3:0]        bus_be,
    input  logic [31:0]       bus_rdata,
    input  logic              bus_ack
);
    logic        active;
    phase_e      phase;
    logic [7:0]  off_q;
    logic [2:0]  w_q;
    logic [1:0]  sh;
    logic [7:0]  cmd;

    // Access sequencing: raise req, drop it on ack, advance phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active    <= 1'b0;
            phase     <= PH_CMD;
            bus_req   <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_byte  <= 8'd0;
            off_q     <= 8'd0;
            w_q       <= 3'd1;
        end else begin
            rsp_valid <= 1'b0;
            if (go && !active) begin
                active  <= 1'b1;
                phase   <= PH_CMD;
                bus_req <= 1'b1;
                off_q   <= offset;
                w_q     <= width;
            end else if (active) begin
                if (bus_req && bus_ack) begin
                    bus_req <= 1'b0;
                    if (phase == PH_READ) rsp_byte <= bus_rdata[7:0];
                    if (phase == PH_RST2) begin
                        active    <= 1'b0;
                        rsp_valid <= 1'b1;
                    end else begin
                        phase <= phase_e'(phase + 2'd1);
                    end
                end else if (!bus_req) begin
                    bus_req <= 1'b1;
                end
            end
        end
    end

    // Address, data and lane decode for the current phase.
    always_comb begin
        sh = w_q[2] ? 2'd2 : (w_q[1] ? 2'd1 : 2'd0);
        bus_be = w_q[2] ? 4'hF : (w_q[1] ? 4'h3 : 4'h1);
        bus_we = (phase != PH_READ);
        cmd    = CMD_RD_STD;
        bus_addr = '0;
        case (phase)
            PH_CMD:  begin cmd = CMD_QUERY;  bus_addr = ADDR_W'(QUERY_ADDR) << sh; end
            PH_READ: begin cmd = 8'd0;       bus_addr = ADDR_W'(off_q) << sh;      end
            PH_RST1: begin cmd = CMD_RD_ALT; bus_addr = '0;                         end
            default: begin cmd = CMD_RD_STD; bus_addr = '0;                         end
        endcase
        bus_wdata = {24'd0, cmd};
    end

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we)); // R11
    AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |-> bus_req); // R11
    AST_GAP_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_ack |=> !bus_req); // R11
    AST_RESET_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(bus_we) && $past(bus_addr) == '0 && $past(bus_wdata[7:0]) == CMD_RD_STD); // R2
endmodule

// File: rtl/fqp_engine.sv
// Flash query probe engine top: walks the query table, detects bus width,
// validates the table and holds decoded fields until the next start.
// Assumes cfg_width is 0, 1, 2 or 4 and start is only pulsed when idle or finished.
module fqp_engine
    import fqp_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int NREG   = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [2:0]           cfg_width,
    output logic                 bus_req,
    output logic                 bus_we,
    output logic [ADDR_W-1:0]    bus_addr,
    output logic [31:0]          bus_wdata,
    output logic [3:0]           bus_be,
    input  logic [31:0]          bus_rdata,
    input  logic                 bus_ack,
    output logic                 done,
    output logic                 err,
    output logic [2:0]           err_code,
    output logic [2:0]           width,
    output logic [15:0]          cmdset,
    output logic [31:0]          size_bytes,
    output logic [7:0]           erase_typ_exp,
    output logic [7:0]           erase_mul_exp,
    output logic [7:0]           write_typ_exp,
    output logic [7:0]           write_mul_exp,
    output logic [7:0]           buf_typ_exp,
    output logic [7:0]           buf_mul_exp,
    output logic [7:0]           buf_log2,
    output logic [7:0]           region_count,
    output logic [NREG*17-1:0]   reg_blocks,
    output logic [NREG*24-1:0]   reg_bsize
);
    localparam int NSTEP = 16 + 4 * NREG;
    localparam int SW    = $clog2(NSTEP + 1);
    // Step indices of the fetch programme
    localparam logic [SW-1:0] S_Q = 0, S_R = 1, S_Y = 2, S_IFHI = 7,
        S_EMUL = 9, S_WMUL = 11, S_BTYP = 12, S_BMUL = 13, S_NREG = 15, S_REG0 = 16;

    typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} state_e;

    state_e          state;
    logic [SW-1:0]   step;
    logic            auto_q;
    logic            go;
    logic [7:0]      raw [NSTEP];
    logic [7:0]      vw  [NSTEP];
    logic [7:0]      offs;
    logic            rsp_valid;
    logic [7:0]      rbyte;
    logic [SW-1:0]   nxt_step;
    logic            fin, retry;
    err_e            fcode;
    logic [15:0]     iface_p1;
    logic            erase_bad, write_bad, buf_bad;
    logic [SW-1:0]   rel;

    // Table offset for each programme step.
    always_comb begin
        case (step)
            SW'(0):  offs = 8'h10;  SW'(1):  offs = 8'h11;  SW'(2):  offs = 8'h12;
            SW'(3):  offs = 8'h13;  SW'(4):  offs = 8'h14;  SW'(5):  offs = 8'h27;
            SW'(6):  offs = 8'h28;  SW'(7):  offs = 8'h29;  SW'(8):  offs = 8'h21;
            SW'(9):  offs = 8'h25;  SW'(10): offs = 8'h1F;  SW'(11): offs = 8'h23;
            SW'(12): offs = 8'h20;  SW'(13): offs = 8'h24;  SW'(14): offs = 8'h2A;
            SW'(15): offs = 8'h2C;
            default: offs = 8'h2D + 8'(step - S_REG0);
        endcase
    end

    fqp_bus_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .go(go), .width(width), .offset(offs),
        .rsp_valid(rsp_valid), .rsp_byte(rbyte),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_rdata(bus_rdata), .bus_ack(bus_ack)
    );

    // Byte view with the byte just fetched merged in at the current step.
    always_comb begin
        for (int i = 0; i < NSTEP; i++)
            vw[i] = (rsp_valid && step == SW'(i)) ? rbyte : raw[i];
    end

    fqp_tmo_rule #(.DEF_TYP(16), .DEF_MUL(4), .LIMIT(41)) u_erase (
        .typ_raw(vw[8]), .mul_raw(vw[9]), .typ_eff(erase_typ_exp), .mul_eff(erase_mul_exp), .bad(erase_bad));
    fqp_tmo_rule #(.DEF_TYP(18), .DEF_MUL(4), .LIMIT(51)) u_write (
        .typ_raw(vw[10]), .mul_raw(vw[11]), .typ_eff(write_typ_exp), .mul_eff(write_mul_exp), .bad(write_bad));
    fqp_tmo_rule #(.DEF_TYP(0), .DEF_MUL(0), .LIMIT(51)) u_buf (
        .typ_raw(vw[12]), .mul_raw(vw[13]), .typ_eff(buf_typ_exp), .mul_eff(buf_mul_exp), .bad(buf_bad));

    // Decide what follows the byte that just arrived.
    always_comb begin
        nxt_step = step + SW'(1);
        fin      = 1'b0;
        retry    = 1'b0;
        fcode    = ERR_NONE;
        iface_p1 = {vw[7], vw[6]} + 16'd1;
        rel      = step - S_REG0;
        if (step == S_Q) begin
            if (rbyte != 8'h51) begin
                if (auto_q && width != 3'd4) retry = 1'b1;
                else begin fin = 1'b1; fcode = ERR_NODEV; end
            end
        end else if (step == S_R || step == S_Y) begin
            if (rbyte != ((step == S_R) ? 8'h52 : 8'h59)) begin fin = 1'b1; fcode = ERR_IDENT; end
        end else if (step == S_IFHI) begin
            if ((iface_p1[2:0] & width) == 3'd0) begin fin = 1'b1; fcode = ERR_IFACE; end
        end else if (step == S_EMUL) begin
            if (erase_bad) begin fin = 1'b1; fcode = ERR_ERASE; end
        end else if (step == S_WMUL) begin
            if (write_bad) begin fin = 1'b1; fcode = ERR_WRITE; end
        end else if (step == S_BMUL) begin
            if (buf_bad) begin fin = 1'b1; fcode = ERR_BUFWR; end
            else if (vw[S_BTYP] == 8'd0) nxt_step = S_NREG;
        end else if (step == S_NREG) begin
            if (rbyte > 8'(NREG)) begin fin = 1'b1; fcode = ERR_REGION; end
            else if (rbyte == 8'd0) fin = 1'b1;
        end else if (step >= S_REG0) begin
            if (rel[1:0] == 2'd3 && 8'(rel >> 2) + 8'd1 == raw[S_NREG]) fin = 1'b1;
        end
    end

    // Main sequencing: start, capture each byte, retry widths, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            step     <= '0;
            auto_q   <= 1'b0;
            go       <= 1'b0;
            width    <= 3'd1;
            done     <= 1'b0;
            err      <= 1'b0;
            err_code <= ERR_NONE;
            for (int i = 0; i < NSTEP; i++) raw[i] <= 8'd0;
        end else begin
            go <= 1'b0;
            if (start && state != ST_RUN) begin
                state    <= ST_RUN;
                step     <= '0;
                auto_q   <= (cfg_width == 3'd0);
                width    <= (cfg_width == 3'd0) ? 3'd1 : cfg_width;
                done     <= 1'b0;
                err      <= 1'b0;
                err_code <= ERR_NONE;
                go       <= 1'b1;
                for (int i = 0; i < NSTEP; i++) raw[i] <= 8'd0;
            end else if (state == ST_RUN && rsp_valid) begin
                raw[step] <= rbyte;
                if (fin) begin
                    state    <= ST_FIN;
                    done     <= (fcode == ERR_NONE);
                    err      <= (fcode != ERR_NONE);
                    err_code <= fcode;
                end else if (retry) begin
                    width <= width << 1;
                    go    <= 1'b1;
                end else begin
                    step <= nxt_step;
                    go   <= 1'b1;
                end
            end
        end
    end

    assign cmdset       = {raw[4], raw[3]};
    assign size_bytes   = (raw[5] < 8'd32) ? (32'd1 << raw[5][4:0]) : 32'd0;
    assign buf_log2     = raw[14];
    assign region_count = raw[S_NREG];

    // Region descriptor decode, one slot per supported region.
    for (genvar g = 0; g < NREG; g++) begin : g_region
        logic [15:0] cnt_f, sz_f;
        logic        used;
        assign cnt_f = {raw[16 + 4*g + 1], raw[16 + 4*g]};
        assign sz_f  = {raw[16 + 4*g + 3], raw[16 + 4*g + 2]};
        assign used  = (8'(g) < raw[S_NREG]);
        assign reg_blocks[g*17 +: 17] = used ? ({1'b0, cnt_f} + 17'd1) : 17'd0;
        assign reg_bsize[g*24 +: 24]  = !used ? 24'd0 : (sz_f == 16'd0) ? 24'd128 : {sz_f, 8'd0};
    end

    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err)); // R12
    AST_DONE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> err_code == 3'd0); // R12
    AST_WIDTH_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        state != ST_IDLE && cfg_width != 3'd3 && cfg_width < 3'd5 |-> $onehot(width)); // R3
    AST_WIDTH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_RUN && $past(state) == ST_RUN && !$stable(width) |-> auto_q && width > $past(width)); // R3
    AST_NO_ACCESS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_FIN && $past(state) == ST_FIN |-> !bus_req); // R12
endmodule

// File: tb/fqp_engine_tb_top.sv
`timescale 1ns/1ps
module fqp_engine_tb_top;
    localparam int ADDR_W = 12;
    localparam int NREG   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [2:0] cfg_width = 3'd0;
    logic bus_req, bus_we, bus_ack;
    logic [ADDR_W-1:0] bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic [3:0] bus_be;
    logic done, err;
    logic [2:0] err_code, width;
    logic [15:0] cmdset;
    logic [31:0] size_bytes;
    logic [7:0] e_t, e_m, w_t, w_m, b_t, b_m, buf_log2, region_count;
    logic [NREG*17-1:0] reg_blocks;
    logic [NREG*24-1:0] reg_bsize;

    always #2.5 clk = ~clk;

    fqp_engine #(.ADDR_W(ADDR_W), .NREG(NREG)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_width(cfg_width),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_be(bus_be), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
        .done(done), .err(err), .err_code(err_code), .width(width), .cmdset(cmdset),
        .size_bytes(size_bytes), .erase_typ_exp(e_t), .erase_mul_exp(e_m),
        .write_typ_exp(w_t), .write_mul_exp(w_m), .buf_typ_exp(b_t), .buf_mul_exp(b_m),
        .buf_log2(buf_log2), .region_count(region_count),
        .reg_blocks(reg_blocks), .reg_bsize(reg_bsize)
    );

    // Flash stub state
    logic [7:0] q [64];
    int  dev_w = 1;
    bit  present = 1'b1;
    bit  qmode = 1'b0;
    int  viol = 0;
    int  rst_exp = 0;
    int  nvec = 0, nbad = 0;

    // Stub: acknowledge next cycle, track query mode, monitor protocol (R1, R2).
    always @(posedge clk) begin
        if (!rst_n) begin
            bus_ack <= 1'b0; bus_rdata <= 32'd0; qmode <= 1'b0;
        end else begin
            bus_ack <= 1'b0;
            if (bus_req && !bus_ack) begin
                bus_ack <= 1'b1;
                if (!(bus_be == 4'h1 || bus_be == 4'h3 || bus_be == 4'hF)) viol <= viol + 1;
                if ((int'(bus_addr) % $countones(bus_be)) != 0) viol <= viol + 1;
                if (cfg_width != 3'd0 && $countones(bus_be) != int'(cfg_width)) viol <= viol + 1;
                if (bus_we) begin
                    if (rst_exp == 1) begin
                        if (bus_addr != 0 || bus_wdata[7:0] != 8'hF0) viol <= viol + 1;
                        rst_exp <= 2;
                    end else if (rst_exp == 2) begin
                        if (bus_addr != 0 || bus_wdata[7:0] != 8'hFF) viol <= viol + 1;
                        rst_exp <= 0;
                    end
                    if (present && int'(bus_addr) == 'h55 * dev_w && bus_wdata[7:0] == 8'h98) qmode <= 1'b1;
                    if (bus_wdata[7:0] == 8'hFF || bus_wdata[7:0] == 8'hF0) qmode <= 1'b0;
                end else begin
                    if (rst_exp != 0) viol <= viol + 1;
                    rst_exp <= 1;
                    if (qmode && (int'(bus_addr) % dev_w) == 0 && (int'(bus_addr) / dev_w) < 64)
                        bus_rdata <= {24'hA5A5A5, q[int'(bus_addr) / dev_w]};
                    else
                        bus_rdata <= 32'h0;
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic base_image(input logic [15:0] cs);
        for (int i = 0; i < 64; i++) q[i] = 8'h00;
        q['h10] = 8'h51; q['h11] = 8'h52; q['h12] = 8'h59;
        q['h13] = cs[7:0]; q['h14] = cs[15:8];
        q['h27] = 8'd23; q['h28] = 8'h06; q['h29] = 8'h00;
        q['h21] = 8'd10; q['h25] = 8'd3; q['h1F] = 8'd9; q['h23] = 8'd2;
        q['h20] = 8'd11; q['h24] = 8'd4; q['h2A] = 8'd8; q['h2C] = 8'd2;
        q['h2D] = 8'h3F; q['h2E] = 8'h00; q['h2F] = 8'h00; q['h30] = 8'h01;
        q['h31] = 8'h07; q['h32] = 8'h01; q['h33] = 8'h00; q['h34] = 8'h00;
    endtask

    // Run one probe and compare every output against arithmetic expectations.
    task automatic probe(input string name);
        int v0, cyc, ew, ecode, et, em, wt, wm, bt, bm, n;
        logic [15:0] ifc;
        v0 = viol;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        cyc = 0;
        while (!(done || err) && cyc < 5000) begin @(negedge clk); cyc++; end
        if (cyc >= 5000) begin nbad++; nvec++; $display("FAIL %s watchdog R12 actual=hang expected=finish", name); end
        // expected width / no device (R3)
        ecode = 0;
        ew = (cfg_width == 0) ? dev_w : int'(cfg_width);
        if (!present || ew != dev_w) ecode = 1;
        else if (q['h11] != 8'h52 || q['h12] != 8'h59) ecode = 2;
        else begin
            ifc = {q['h29], q['h28]} + 16'd1;
            et = (q['h21] == 0) ? 16 : q['h21]; em = (q['h25] == 0) ? 4 : q['h25];
            wt = (q['h1F] == 0) ? 18 : q['h1F]; wm = (q['h23] == 0) ? 4 : q['h23];
            bt = q['h20]; bm = q['h24];
            if ((ifc & 16'(ew)) == 0) ecode = 3;
            else if (et > 41 || et + em > 41) ecode = 4;
            else if (wt > 51 || wt + wm > 51) ecode = 5;
            else if (bt > 51 || bt + bm > 51) ecode = 6;
            else if (q['h2C] > NREG) ecode = 7;
        end
        chk({name, " R12 err flag"}, 32'(err), 32'(ecode != 0));
        chk({name, " R12 done flag"}, 32'(done), 32'(ecode == 0));
        chk({name, " R3/R4/R6-R10 err_code"}, 32'(err_code), 32'(ecode));
        chk({name, " R1/R2/R11 bus protocol"}, 32'(viol - v0), 32'd0);
        chk({name, " R2 left in read mode"}, 32'(qmode), 32'd0);
        if (ecode != 1) chk({name, " R3 width"}, 32'(width), 32'(ew));
        if (ecode == 0) begin
            chk({name, " R5 cmdset"}, 32'(cmdset), {16'd0, q['h14], q['h13]});
            chk({name, " R5 size"}, size_bytes, (q['h27] < 32) ? (32'd1 << q['h27]) : 32'd0);
            chk({name, " R7 erase exps"}, {16'd0, e_t, e_m}, {16'd0, 8'(et), 8'(em)});
            chk({name, " R8 write exps"}, {16'd0, w_t, w_m}, {16'd0, 8'(wt), 8'(wm)});
            chk({name, " R9 buf exps"}, {16'd0, b_t, b_m}, {16'd0, 8'(bt), 8'(bm)});
            chk({name, " R9 buf_log2"}, 32'(buf_log2), (bt != 0) ? 32'(q['h2A]) : 32'd0);
            n = q['h2C];
            chk({name, " R10 count"}, 32'(region_count), 32'(n));
            for (int g = 0; g < NREG; g++) begin
                logic [16:0] eb; logic [23:0] es; logic [15:0] f;
                f  = {q['h30 + 4*g], q['h2F + 4*g]};
                eb = (g < n) ? ({1'b0, q['h2E + 4*g], q['h2D + 4*g]} + 17'd1) : 17'd0;
                es = (g >= n) ? 24'd0 : (f == 0) ? 24'd128 : 24'(f) * 24'd256;
                chk({name, " R10 blocks"}, 32'(reg_blocks[g*17 +: 17]), 32'(eb));
                chk({name, " R10 bsize"}, 32'(reg_bsize[g*24 +: 24]), 32'(es));
            end
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        nbad++;
        $display("FAIL global watchdog R12 actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R12 reset done", 32'(done), 0);
        chk("R12 reset err", 32'(err), 0);
        chk("R11 reset req", 32'(bus_req), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 auto-detect and fixed width, every device width
        foreach (dev_w_list[k]) ;
        for (int k = 0; k < 3; k++) begin
            dev_w = 1 << k; present = 1'b1;
            base_image(16'h0100 + 16'(k));
            cfg_width = 3'd0; probe("auto");
            cfg_width = 3'(dev_w); probe("fixed");
        end
        // R3 mismatch and absent device
        dev_w = 2; cfg_width = 3'd4; probe("mismatch");
        present = 1'b0; cfg_width = 3'd0; probe("absent");
        present = 1'b1; dev_w = 4; cfg_width = 3'd0;
        // R4 identification
        base_image(16'h0002); q['h11] = 8'h51; probe("badR");
        base_image(16'h0002); q['h12] = 8'h58; probe("badY");
        // R5 size edges
        base_image(16'h0003); q['h27] = 8'd31; probe("size31");
        base_image(16'h0003); q['h27] = 8'd32; probe("size32");
        // R6 interface code against each width
        for (int k = 0; k < 3; k++) begin
            dev_w = 1 << k;
            for (int c = 0; c < 6; c++) begin
                base_image(16'h0001);
                if (c == 5) begin q['h28] = 8'hFF; q['h29] = 8'hFF; end
                else q['h28] = 8'(c);
                probe("iface");
            end
        end
        dev_w = 2;
        // R7 erase timeouts
        for (int a = 0; a < 4; a++) for (int b = 0; b < 4; b++) begin
            base_image(16'h0001);
            q['h21] = (a == 0) ? 8'd0 : (a == 1) ? 8'd16 : (a == 2) ? 8'd41 : 8'd42;
            q['h25] = (b == 0) ? 8'd0 : (b == 1) ? 8'd1 : (b == 2) ? 8'd25 : 8'd26;
            probe("erase");
        end
        // R8 write timeouts
        for (int a = 0; a < 4; a++) for (int b = 0; b < 3; b++) begin
            base_image(16'h0001);
            q['h1F] = (a == 0) ? 8'd0 : (a == 1) ? 8'd18 : (a == 2) ? 8'd51 : 8'd52;
            q['h23] = (b == 0) ? 8'd0 : (b == 1) ? 8'd33 : 8'd34;
            probe("write");
        end
        // R9 buffered timeouts, no defaults
        for (int a = 0; a < 4; a++) for (int b = 0; b < 3; b++) begin
            base_image(16'h0001);
            q['h20] = (a == 0) ? 8'd0 : (a == 1) ? 8'd20 : (a == 2) ? 8'd51 : 8'd52;
            q['h24] = (b == 0) ? 8'd0 : (b == 1) ? 8'd31 : 8'd32;
            probe("bufwr");
        end
        // R10 region counts 0..NREG+1
        for (int n = 0; n <= NREG + 1; n++) begin
            base_image(16'h0001);
            q['h2C] = 8'(n);
            for (int g = 0; g < NREG; g++) begin
                q['h2D + 4*g] = 8'(g * 37 + 5); q['h2E + 4*g] = 8'(g);
                q['h2F + 4*g] = (g == 1) ? 8'd0 : 8'(g + 2); q['h30 + 4*g] = (g == 3) ? 8'hFF : 8'd0;
            end
            probe("regions");
        end
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    int dev_w_list [1] = '{0};
endmodule